// File: doc/BRIEF.md
# Memory Ordering Queue with Store Forwarding

This block keeps every in-flight memory operation, load or store, in a circular queue in program order. A slot is claimed at the tail when an operation is dispatched. A store's address and its data arrive later and separately, on their own update ports, whenever the pipeline has computed them. When a load presents its address, the queue looks at every store older than that load. The load then does one of three things: it reads the backing memory, it takes data straight from the queue, or it is told to retry.

Stores change the backing memory only when they retire from the head of the queue, one per cycle and in program order. Loads may run before all older store addresses are known. When such an address later turns out to alias a load that has already executed, the queue raises a one-cycle ordering-violation pulse that names the oldest offending load. A flush port trims the queue back to a chosen entry so that wrong-path work is dropped. The backing memory is a plain synchronous word array inside the block.

Top module: `lsq_top`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `full` is 0, `alloc_idx` is 0, `head_ready` is 0, and neither `ld_resp_valid` nor `viol_valid` is asserted.
- R2: Each accepted allocation takes the entry shown on `alloc_idx`, and the index then advances by one modulo DEPTH. Once DEPTH entries are live, `full` is 1 and further allocation requests leave `alloc_idx` unchanged.
- R3: A load that is not stalled receives its result on `ld_resp_data` one cycle later, with `ld_resp_valid` = 1. If no older store with a resolved address matches its address, the result is the memory word and `ld_resp_fwd` = 0.
- R4: If an older store with a resolved address and valid data matches the load's address, the load returns that store's data with `ld_resp_fwd` = 1.
- R5: When several older stores match, the youngest of them that is still older than the load supplies the data. Stores younger than the load are never considered.
- R6: If the youngest matching older store has no data yet, `ld_stall` is 1 in the same cycle and no response follows. A retry after the data arrives forwards that data.
- R7: Older stores whose address has not resolved are skipped by the search, so the load proceeds speculatively.
- R8: `head_ready` is 1 only when the head entry is a store with address and data present, or a load that has executed. Only then does `commit_valid` retire it. A retiring store writes its data to memory, so the last committed store to an address is the one a later load reads.
- R9: When a store address resolves and matches a younger load that has already executed or is executing in that same cycle, `viol_valid` pulses for one cycle in the next cycle, with `viol_idx` set to the oldest such load. A non-matching address, or a match only with loads that have not executed, gives no pulse.
- R10: `flush_valid` keeps the entries from the head up to and including `flush_idx` and discards all younger ones. `alloc_idx` becomes `flush_idx`+1, and discarded stores never reach memory. A flush takes priority over a same-cycle allocation or commit, and both of those are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Request to claim the tail entry |
| alloc_is_store | input | 1 | 1 = the new entry is a store, 0 = a load |
| alloc_idx | output | IW | Index the next allocation receives |
| full | output | 1 | All DEPTH entries are live |
| st_addr_valid | input | 1 | A store address is resolving this cycle |
| st_addr_idx | input | IW | Entry of that store |
| st_addr | input | AW | Resolved store address |
| st_data_valid | input | 1 | Store data is arriving this cycle |
| st_data_idx | input | IW | Entry of that store |
| st_data | input | DW | Store data |
| ld_req_valid | input | 1 | A load is executing this cycle |
| ld_idx | input | IW | Entry of that load |
| ld_addr | input | AW | Load address |
| ld_stall | output | 1 | The load must retry (matching store lacks data) |
| ld_resp_valid | output | 1 | Load result is valid |
| ld_resp_data | output | DW | Load result |
| ld_resp_fwd | output | 1 | Result came from a queued store |
| commit_valid | input | 1 | Retire the head entry if it is ready |
| head_ready | output | 1 | The head entry may retire |
| flush_valid | input | 1 | Discard entries younger than flush_idx |
| flush_idx | input | IW | Youngest entry that survives the flush |
| viol_valid | output | 1 | Ordering violation detected |
| viol_idx | output | IW | Oldest load that read too early |

## Verification
The bench sets up three stores to one address around a single load and expects the middle store's value. A design that picked the oldest match, or that let a store younger than the load win, would return a different word. A load whose matching store lacks data must see `ld_stall`; a design that fell through to memory would hand back the stale word with the forward flag clear. A load that executes past a store with no address must read memory, and two executed loads that alias a late store address must give one violation naming the older load, including the case where the load issues in the same cycle as the address. The bench also fills the queue to the brim across the pointer wrap and flushes away a store that already holds its data. A design that let the flushed store commit, or that moved the tail on an allocation while full, would show a wrong memory word or a wrong `alloc_idx`.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
// Package: shared per-entry status type for the memory ordering queue.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package lsq_pkg;

    // Status bits that every queue entry carries.
    typedef struct packed {
        logic valid;     // entry is live
        logic is_store;  // 1 = store, 0 = load
        logic addr_ok;   // store address resolved
        logic data_ok;   // store data present
        logic done;      // load has executed
    } lsq_flags_t;

endpackage

// File: rtl/lsq_scan.sv
`timescale 1ns/1ps
// Module: lsq_scan
// Walks the queue from the head up to (not including) the load's entry
// and reports the youngest resolved store whose address equals the load
// address, with its data and whether that data is present.
// Assumes DEPTH is a power of two so index arithmetic wraps naturally.
module lsq_scan #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] st_live,
    input  logic [DEPTH-1:0] st_dready,
    input  logic [AW-1:0]    ent_addr [DEPTH],
    input  logic [DW-1:0]    ent_data [DEPTH],
    input  logic [IW-1:0]    head,
    input  logic [IW-1:0]    ld_idx,
    input  logic [AW-1:0]    ld_addr,
    output logic             hit,
    output logic             hit_ready,
    output logic [DW-1:0]    hit_data
);

    logic [IW-1:0] ld_age;

    // Oldest-to-youngest sweep; a later match overwrites an earlier one.
    always_comb begin
        ld_age    = ld_idx - head;
        hit       = 1'b0;
        hit_ready = 1'b0;
        hit_data  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (IW'(k) < ld_age
                && st_live[IW'(head + IW'(k))]
                && ent_addr[IW'(head + IW'(k))] == ld_addr) begin
                hit       = 1'b1;
                hit_ready = st_dready[IW'(head + IW'(k))];
                hit_data  = ent_data[IW'(head + IW'(k))];
            end
        end
    end

endmodule

// File: rtl/lsq_viol.sv
`timescale 1ns/1ps
// Module: lsq_viol
// Given a store address resolving this cycle, finds the oldest younger
// load that already executed (or is executing now) at the same address.
// Assumes DEPTH is a power of two; the caller gates the result with the
// store-address strobe.
module lsq_viol #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] ld_live,
    input  logic [AW-1:0]    ent_addr [DEPTH],
    input  logic [IW-1:0]    head,
    input  logic [IW-1:0]    st_idx,
    input  logic [AW-1:0]    st_addr,
    input  logic             ld_fire,
    input  logic [IW-1:0]    ld_idx,
    input  logic [AW-1:0]    ld_addr,
    output logic             found,
    output logic [IW-1:0]    found_idx
);

    logic [IW-1:0] st_age;

    // Youngest-to-oldest sweep so the oldest offending load wins.
    always_comb begin
        st_age    = st_idx - head;
        found     = 1'b0;
        found_idx = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (IW'(k) > st_age
                && ((ld_live[IW'(head + IW'(k))]
                     && ent_addr[IW'(head + IW'(k))] == st_addr)
                    || (ld_fire && ld_idx == IW'(head + IW'(k))
                        && ld_addr == st_addr))) begin
                found     = 1'b1;
                found_idx = IW'(head + IW'(k));
            end
        end
    end

endmodule

// File: rtl/lsq_mem.sv
`timescale 1ns/1ps
// Module: lsq_mem
// Single-port-write, single-port-read synchronous word array. Read data
// appears one cycle after the address. Contents are not reset.
module lsq_mem #(
    parameter int AW = 8,
    parameter int DW = 16,
    localparam int WORDS = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [WORDS];

    // Write on commit, registered read every cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/lsq_top.sv
`timescale 1ns/1ps
// Module: lsq_top
// Circular queue of in-flight loads and stores in program order, with an
// older-store search for each load (forward / read memory / stall),
// in-order store retirement into a local memory, late-address ordering
// violation detection and a flush that trims younger entries.
// Assumes: DEPTH is a power of two; the caller drives update ports only
// for live entries of the right kind; synchronous active-low reset.
module lsq_top
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_is_store,
    output logic [IW-1:0] alloc_idx,
    output logic          full,
    input  logic          st_addr_valid,
    input  logic [IW-1:0] st_addr_idx,
    input  logic [AW-1:0] st_addr,
    input  logic          st_data_valid,
    input  logic [IW-1:0] st_data_idx,
    input  logic [DW-1:0] st_data,
    input  logic          ld_req_valid,
    input  logic [IW-1:0] ld_idx,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_stall,
    output logic          ld_resp_valid,
    output logic [DW-1:0] ld_resp_data,
    output logic          ld_resp_fwd,
    input  logic          commit_valid,
    output logic          head_ready,
    input  logic          flush_valid,
    input  logic [IW-1:0] flush_idx,
    output logic          viol_valid,
    output logic [IW-1:0] viol_idx
);

    lsq_flags_t    flags    [DEPTH];
    logic [AW-1:0] ent_addr [DEPTH];
    logic [DW-1:0] ent_data [DEPTH];
    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    logic [DEPTH-1:0] st_live, st_dready, ld_live;
    logic             alloc_fire, commit_fire, ld_fire;
    logic [IW-1:0]    flush_age;
    logic             fwd_hit, fwd_ready;
    logic [DW-1:0]    fwd_data;
    logic             vfound;
    logic [IW-1:0]    vfound_idx;
    logic             fwd_q;
    logic [DW-1:0]    fwd_data_q;
    logic [DW-1:0]    mem_rdata;
    lsq_flags_t       hf;

    // Per-entry summary vectors for the search and violation units.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            st_live[i]   = flags[i].valid && flags[i].is_store && flags[i].addr_ok;
            st_dready[i] = flags[i].data_ok;
            ld_live[i]   = flags[i].valid && !flags[i].is_store && flags[i].done;
        end
    end

    // Control strobes: occupancy, head readiness, accepted operations.
    always_comb begin
        hf          = flags[head_q];
        full        = (count_q == CW'(DEPTH));
        head_ready  = hf.valid && (hf.is_store ? (hf.addr_ok && hf.data_ok) : hf.done);
        alloc_fire  = alloc_valid && !full && !flush_valid;
        commit_fire = commit_valid && head_ready && !flush_valid;
        flush_age   = flush_idx - head_q;
        ld_stall    = ld_req_valid && fwd_hit && !fwd_ready;
        ld_fire     = ld_req_valid && !ld_stall;
        alloc_idx   = tail_q;
    end

    lsq_scan #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_scan (
        .st_live   (st_live),
        .st_dready (st_dready),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .head      (head_q),
        .ld_idx    (ld_idx),
        .ld_addr   (ld_addr),
        .hit       (fwd_hit),
        .hit_ready (fwd_ready),
        .hit_data  (fwd_data)
    );

    lsq_viol #(.DEPTH(DEPTH), .AW(AW)) u_viol (
        .ld_live   (ld_live),
        .ent_addr  (ent_addr),
        .head      (head_q),
        .st_idx    (st_addr_idx),
        .st_addr   (st_addr),
        .ld_fire   (ld_fire),
        .ld_idx    (ld_idx),
        .ld_addr   (ld_addr),
        .found     (vfound),
        .found_idx (vfound_idx)
    );

    lsq_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (commit_fire && hf.is_store),
        .waddr (ent_addr[head_q]),
        .wdata (ent_data[head_q]),
        .raddr (ld_addr),
        .rdata (mem_rdata)
    );

    // Head, tail and occupancy bookkeeping; flush overrides the rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush_valid) begin
            tail_q  <= flush_idx + 1'b1;
            count_q <= CW'(flush_age) + 1'b1;
        end else begin
            if (alloc_fire)  tail_q <= tail_q + 1'b1;
            if (commit_fire) head_q <= head_q + 1'b1;
            count_q <= count_q + CW'(alloc_fire) - CW'(commit_fire);
        end
    end

    // Entry status: allocate, resolve, execute, retire, discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) flags[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_fire && tail_q == IW'(i)) begin
                    flags[i]          <= '0;
                    flags[i].valid    <= 1'b1;
                    flags[i].is_store <= alloc_is_store;
                end
                if (st_addr_valid && st_addr_idx == IW'(i)) flags[i].addr_ok <= 1'b1;
                if (st_data_valid && st_data_idx == IW'(i)) flags[i].data_ok <= 1'b1;
                if (ld_fire && ld_idx == IW'(i))            flags[i].done    <= 1'b1;
                if (commit_fire && head_q == IW'(i))        flags[i].valid   <= 1'b0;
                if (flush_valid && IW'(IW'(i) - head_q) > flush_age)
                    flags[i].valid <= 1'b0;
            end
        end
    end

    // Entry payload: store address/data and executed load address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (st_addr_valid && st_addr_idx == IW'(i)) ent_addr[i] <= st_addr;
            if (ld_fire && ld_idx == IW'(i))            ent_addr[i] <= ld_addr;
            if (st_data_valid && st_data_idx == IW'(i)) ent_data[i] <= st_data;
        end
    end

    // Load response register: forward path or memory path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_resp_valid <= 1'b0;
            fwd_q         <= 1'b0;
            fwd_data_q    <= '0;
        end else begin
            ld_resp_valid <= ld_fire;
            fwd_q         <= fwd_hit;
            fwd_data_q    <= fwd_data;
        end
    end

    // Violation pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_idx   <= '0;
        end else begin
            viol_valid <= st_addr_valid && vfound;
            viol_idx   <= vfound_idx;
        end
    end

    assign ld_resp_fwd  = fwd_q;
    assign ld_resp_data = fwd_q ? fwd_data_q : mem_rdata;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && alloc_valid && !flush_valid && !commit_valid |=> alloc_idx == $past(alloc_idx));

    // R3
    resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_resp_valid |-> $past(ld_req_valid && !ld_stall));

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_valid && ld_stall |=> !ld_resp_valid);

    // R8
    commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid && head_ready && !flush_valid |=> head_q == IW'($past(head_q) + 1'b1));

    // R9
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $past(st_addr_valid));

    // R10
    flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> alloc_idx == IW'($past(flush_idx) + 1'b1));

endmodule

// File: tb/sim_lsq_top.sv
`timescale 1ns/1ps
// Bench for lsq_top: a table of queue operations with expected results,
// walked by one loop, followed by directed reset, full, flush and
// same-cycle violation tests.
module sim_lsq_top;

    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          alloc_valid, alloc_is_store;
    logic [IW-1:0] alloc_idx;
    logic          full;
    logic          st_addr_valid;
    logic [IW-1:0] st_addr_idx;
    logic [7:0]    st_addr;
    logic          st_data_valid;
    logic [IW-1:0] st_data_idx;
    logic [15:0]   st_data;
    logic          ld_req_valid;
    logic [IW-1:0] ld_idx;
    logic [7:0]    ld_addr;
    logic          ld_stall, ld_resp_valid, ld_resp_fwd;
    logic [15:0]   ld_resp_data;
    logic          commit_valid, head_ready;
    logic          flush_valid;
    logic [IW-1:0] flush_idx;
    logic          viol_valid;
    logic [IW-1:0] viol_idx;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lsq_top u0 (.*);

    // Step encoding: {op[4], idx[4], addr[8], data[16], exp[16], req[4]}
    localparam logic [3:0] AS = 0, AL = 1, SA = 2, SV = 3, SD = 4,
                           LD = 5, LF = 6, LS = 7, CM = 8, FL = 9;
    localparam int NSTEPS = 61;
    localparam logic [51:0] STEPS [NSTEPS] = '{
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd2},  // R2
        {SA, 4'd0, 8'h10, 16'h0000, 16'h0000, 4'd9},
        {SD, 4'd0, 8'h00, 16'h1111, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},  // R8
        {AL, 4'd0, 8'h00, 16'h0000, 16'h0001, 4'd2},
        {LD, 4'd1, 8'h10, 16'h0000, 16'h1111, 4'd3},  // R3
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0002, 4'd2},
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0003, 4'd2},
        {AL, 4'd0, 8'h00, 16'h0000, 16'h0004, 4'd2},
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0005, 4'd2},
        {SA, 4'd2, 8'h20, 16'h0000, 16'h0000, 4'd9},
        {SD, 4'd2, 8'h00, 16'hAAAA, 16'h0000, 4'd5},
        {SA, 4'd3, 8'h20, 16'h0000, 16'h0000, 4'd9},
        {SD, 4'd3, 8'h00, 16'hBBBB, 16'h0000, 4'd5},
        {SA, 4'd5, 8'h20, 16'h0000, 16'h0000, 4'd9},  // R9 load not executed
        {SD, 4'd5, 8'h00, 16'hCCCC, 16'h0000, 4'd5},
        {LF, 4'd4, 8'h20, 16'h0000, 16'hBBBB, 4'd5},  // R5 youngest older
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {AL, 4'd0, 8'h00, 16'h0000, 16'h0006, 4'd2},
        {LD, 4'd6, 8'h20, 16'h0000, 16'hCCCC, 4'd8},  // R8 last store wins
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0007, 4'd2},
        {AL, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd2},  // R2 wrap
        {SA, 4'd7, 8'h30, 16'h0000, 16'h0000, 4'd9},
        {LS, 4'd0, 8'h30, 16'h0000, 16'h0000, 4'd6},  // R6 stall
        {SD, 4'd7, 8'h00, 16'h7777, 16'h0000, 4'd6},
        {LF, 4'd0, 8'h30, 16'h0000, 16'h7777, 4'd4},  // R4 and R6 retry
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0001, 4'd2},
        {AL, 4'd0, 8'h00, 16'h0000, 16'h0002, 4'd2},
        {LD, 4'd2, 8'h10, 16'h0000, 16'h1111, 4'd7},  // R7 unresolved store skipped
        {SA, 4'd1, 8'h40, 16'h0000, 16'h0000, 4'd9},  // R9 no alias
        {SD, 4'd1, 8'h00, 16'h4444, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0003, 4'd2},
        {AL, 4'd0, 8'h00, 16'h0000, 16'h0004, 4'd2},
        {AL, 4'd0, 8'h00, 16'h0000, 16'h0005, 4'd2},
        {LD, 4'd4, 8'h20, 16'h0000, 16'hCCCC, 4'd7},
        {LD, 4'd5, 8'h20, 16'h0000, 16'hCCCC, 4'd7},
        {SV, 4'd3, 8'h20, 16'h0000, 16'h0004, 4'd9},  // R9 oldest offender
        {SD, 4'd3, 8'h00, 16'h5555, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0006, 4'd2},
        {AS, 4'd0, 8'h00, 16'h0000, 16'h0007, 4'd2},
        {SA, 4'd7, 8'h50, 16'h0000, 16'h0000, 4'd9},
        {SD, 4'd7, 8'h00, 16'h9999, 16'h0000, 4'd10},
        {SA, 4'd6, 8'h50, 16'h0000, 16'h0000, 4'd9},
        {SD, 4'd6, 8'h00, 16'h6666, 16'h0000, 4'd10},
        {FL, 4'd6, 8'h00, 16'h0000, 16'h0007, 4'd10}, // R10 drop entry 7
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8},
        {AL, 4'd0, 8'h00, 16'h0000, 16'h0007, 4'd2},
        {LD, 4'd7, 8'h50, 16'h0000, 16'h6666, 4'd10}, // R10 flushed store absent
        {CM, 4'd0, 8'h00, 16'h0000, 16'h0000, 4'd8}
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_is_store = 0;
        st_addr_valid = 0; st_addr_idx = 0; st_addr = 0;
        st_data_valid = 0; st_data_idx = 0; st_data = 0;
        ld_req_valid = 0; ld_idx = 0; ld_addr = 0;
        commit_valid = 0; flush_valid = 0; flush_idx = 0;
    endtask

    task automatic run_step(input logic [51:0] e);
        logic [3:0]  op;
        logic [2:0]  idx;
        logic [7:0]  ad;
        logic [15:0] dt, ex;
        int          rq;
        op = e[51:48]; idx = e[46:44]; ad = e[43:36];
        dt = e[35:20]; ex = e[19:4]; rq = int'(e[3:0]);
        @(negedge clk);
        case (op)
            AS, AL: begin alloc_valid = 1; alloc_is_store = (op == AS); end
            SA, SV: begin st_addr_valid = 1; st_addr_idx = idx; st_addr = ad; end
            SD:     begin st_data_valid = 1; st_data_idx = idx; st_data = dt; end
            LD, LF, LS: begin ld_req_valid = 1; ld_idx = idx; ld_addr = ad; end
            CM:     commit_valid = 1;
            FL:     begin flush_valid = 1; flush_idx = idx; end
            default: ;
        endcase
        #1;
        if (op == AS || op == AL)
            check(alloc_idx == ex[2:0], rq, "alloc index", 16'(alloc_idx), ex);
        if (op == LD || op == LF)
            check(!ld_stall, rq, "unexpected stall", 16'(ld_stall), 16'h0);
        if (op == LS)
            check(ld_stall, rq, "stall", 16'(ld_stall), 16'h1);
        if (op == CM)
            check(head_ready, rq, "head ready", 16'(head_ready), 16'h1);
        @(posedge clk);
        #1;
        case (op)
            SA: check(!viol_valid, rq, "spurious violation", 16'(viol_valid), 16'h0);
            SV: check(viol_valid && viol_idx == ex[2:0], rq, "violation index",
                      {viol_valid, 12'h0, viol_idx}, {1'b1, 12'h0, ex[2:0]});
            LD: check(ld_resp_valid && !ld_resp_fwd && ld_resp_data == ex, rq,
                      "memory read", ld_resp_data, ex);
            LF: check(ld_resp_valid && ld_resp_fwd && ld_resp_data == ex, rq,
                      "forwarded data", ld_resp_data, ex);
            LS: check(!ld_resp_valid, rq, "response after stall", 16'(ld_resp_valid), 16'h0);
            FL: check(alloc_idx == ex[2:0], rq, "tail after flush", 16'(alloc_idx), ex);
            default: ;
        endcase
        idle();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check(!full && alloc_idx == 0 && !head_ready && !ld_resp_valid && !viol_valid,
              1, "reset state",
              {11'h0, full, alloc_idx, head_ready}, 16'h0000);

        for (int s = 0; s < NSTEPS; s++) run_step(STEPS[s]);

        // R2 fill to capacity (head = tail = 0 here)
        for (int i = 0; i < 8; i++) run_step({AL, 4'd0, 8'h00, 16'h0, 16'(i), 4'd2});
        @(negedge clk); #1;
        check(full, 2, "full flag", 16'(full), 16'h1);
        alloc_valid = 1;
        @(posedge clk); #1;
        idle();
        // R2 request while full must not move the tail
        check(full && alloc_idx == 0, 2, "alloc ignored when full",
              {full, 12'h0, alloc_idx}, 16'h8000);
        // R8 unexecuted load at head cannot retire
        check(!head_ready, 8, "head not ready", 16'(head_ready), 16'h0);

        // R10 flush keeps only entry 0
        run_step({FL, 4'd0, 8'h00, 16'h0, 16'h1, 4'd10});
        check(!full, 10, "not full after flush", 16'(full), 16'h0);
        run_step({LD, 4'd0, 8'h10, 16'h0, 16'h1111, 4'd3});
        run_step({CM, 4'd0, 8'h00, 16'h0, 16'h0, 4'd8});

        // R9 store address resolves in the same cycle a younger load executes
        run_step({AS, 4'd0, 8'h00, 16'h0, 16'h1, 4'd2});
        run_step({AL, 4'd0, 8'h00, 16'h0, 16'h2, 4'd2});
        @(negedge clk);
        st_addr_valid = 1; st_addr_idx = 1; st_addr = 8'h60;
        ld_req_valid = 1; ld_idx = 2; ld_addr = 8'h60;
        #1;
        check(!ld_stall, 9, "concurrent load not stalled", 16'(ld_stall), 16'h0);
        @(posedge clk); #1;
        idle();
        check(viol_valid && viol_idx == 2 && ld_resp_valid, 9, "same-cycle violation",
              {viol_valid, 12'h0, viol_idx}, 16'h8002);
        @(posedge clk); #1;
        check(!viol_valid, 9, "violation is one pulse", 16'(viol_valid), 16'h0);
        run_step({SD, 4'd1, 8'h00, 16'h1234, 16'h0, 4'd8});
        run_step({CM, 4'd0, 8'h00, 16'h0, 16'h0, 4'd8});
        run_step({CM, 4'd0, 8'h00, 16'h0, 16'h0, 4'd8});

        finish_run();
    end

endmodule